// File: doc/BRIEF.md
# Shadow register set controller

This block keeps the processor status word, the exception-status word and one saved-status word for each shadow register set. It also holds the register file, with one bank for the normal set and one bank for each shadow set. The set in use is a field inside the status word. Software cannot move it with an ordinary status write. It changes in two ways only: when an interrupt is taken and a set is requested, or when an exception return restores a saved status word together with the set number placed in it.

On interrupt entry the block saves the old status into the requested set's saved-status word. It does so only when a shadow set is requested and the exception-handler-mode input is low. The block then selects the requested set. On exception return, the normal set restores from the exception-status word and a shadow set restores from its own saved-status word. A second read port fetches any register of any chosen set, for example to copy a stack pointer between sets.

Top module: `regset_ctrl`

## Requirements
- R1: After reset, status, exception status and every saved-status word are zero, and the current set is 0 (the normal set).
- R2: On interrupt entry with a requested set other than 0 and the handler-mode input low, the status word before entry is stored into that set's saved-status word, which shows on `sstat_o` in the next cycle.
- R3: On interrupt entry with the handler-mode input high, no saved-status word changes. With requested set 0, the old status goes to the exception-status word instead.
- R4: A software status write updates every bit except the current-set field (status bits [9:8]), which keeps its value.
- R5: An exception return taken in set 0 loads status, including the set field, from the exception-status word.
- R6: An exception return taken in a shadow set loads status, including the set field, from that set's saved-status word.
- R7: When interrupt entry and exception return are pulsed in the same cycle, only the interrupt entry takes effect.
- R8: Interrupt entry clears the interrupt-enable bit (status bit 0) and sets the current-set field to the requested set.
- R9: The register-file access in the cycle right after a set change already uses the new set's bank.
- R10: The cross-set read port returns the register at the selected address of the selected set, whatever the current set is.
- R11: When shadow sets are configured out, `sstat_o` reads zero and the current set stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_take | input | 1 | Interrupt entry pulse |
| irq_set | input | SET_W | Requested register set (0 = none) |
| hnd_mode | input | 1 | Exception-handler-mode flag |
| eret | input | 1 | Exception return pulse |
| stat_we | input | 1 | Software status write |
| stat_wdata | input | STAT_W | Status write data |
| estat_we | input | 1 | Exception-status write |
| estat_wdata | input | STAT_W | Exception-status write data |
| sstat_we | input | 1 | Saved-status write for the current set |
| sstat_wdata | input | STAT_W | Saved-status write data |
| stat_o | output | STAT_W | Status word |
| estat_o | output | STAT_W | Exception-status word |
| sstat_o | output | STAT_W | Saved-status word of the current set |
| cur_set_o | output | SET_W | Current register set |
| rf_we | input | 1 | Register write into the current set |
| rf_waddr | input | ADDR_W | Write address |
| rf_wdata | input | DATA_W | Write data |
| rf_raddr | input | ADDR_W | Read address in the current set |
| rf_rdata | output | DATA_W | Read data from the current set |
| xr_set | input | SET_W | Set for the cross-set read |
| xr_addr | input | ADDR_W | Address for the cross-set read |
| xr_data | output | DATA_W | Cross-set read data |

## Verification
The set-switching logic is driven through one sequence that moves among the normal set and shadow sets 1, 2 and 3. Interrupt entry is tried three ways: with a shadow set requested and the handler-mode input low, which shows that the save happens; with the handler-mode input high, which shows that it is suppressed; and with set 0 requested, which shows the old status going to exception status. Exception returns from a shadow set and from the normal set confirm the choice of restore source. A status write that carries set bits shows those bits are discarded. A same-cycle interrupt entry and return shows the priority. The same register address is written in two sets, which separates current-set reads from cross-set reads. A second instance with shadow sets disabled shows the flat behaviour.

// File: rtl/regset_ctrl_pkg.sv
package regset_ctrl_pkg;
    // Field positions inside the status word
    localparam int IE_BIT  = 0;
    localparam int CRS_LSB = 8;
endpackage

// File: rtl/regset_rf.sv
module regset_rf #(
    parameter int NUM_SETS = 4,
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SET_W-1:0]  wset,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SET_W-1:0]  rset,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [SET_W-1:0]  xset,
    input  logic [ADDR_W-1:0] xaddr,
    output logic [DATA_W-1:0] xdata
);
    logic [DATA_W-1:0] bank_rd [NUM_SETS];
    logic [DATA_W-1:0] bank_xr [NUM_SETS];

    // One bank per register set
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_bank
        logic [DATA_W-1:0] mem_q [NUM_REGS];
        always_ff @(posedge clk) begin
            if (we && (wset == SET_W'(s))) mem_q[waddr] <= wdata;
        end
        assign bank_rd[s] = mem_q[raddr];
        assign bank_xr[s] = mem_q[xaddr];
    end

    assign rdata = bank_rd[rset];
    assign xdata = bank_xr[xset];
endmodule

// File: rtl/regset_stat.sv
module regset_stat
    import regset_ctrl_pkg::*;
#(
    parameter int NUM_SETS  = 4,
    parameter int STAT_W    = 16,
    parameter bit SHADOW_EN = 1'b1,
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_take,
    input  logic [SET_W-1:0]  irq_set,
    input  logic              hnd_mode,
    input  logic              eret,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              estat_we,
    input  logic [STAT_W-1:0] estat_wdata,
    input  logic              sstat_we,
    input  logic [STAT_W-1:0] sstat_wdata,
    output logic [STAT_W-1:0] stat_o,
    output logic [STAT_W-1:0] estat_o,
    output logic [STAT_W-1:0] sstat_o,
    output logic [SET_W-1:0]  cur_set_o
);
    typedef struct packed {
        logic [STAT_W-1:0]                 stat;
        logic [STAT_W-1:0]                 estat;
        logic [NUM_SETS-1:0][STAT_W-1:0]   sst;
    } st_t;

    st_t              st_d, st_q;
    logic [SET_W-1:0] cur_set;
    logic [SET_W-1:0] tgt_set;

    assign cur_set = st_q.stat[CRS_LSB +: SET_W];

    always_comb begin
        st_d    = st_q;
        tgt_set = SHADOW_EN ? irq_set : '0;
        if (irq_take) begin
            // Entry has priority over return and software writes
            if (tgt_set != '0 && !hnd_mode) st_d.sst[tgt_set] = st_q.stat;
            else if (tgt_set == '0)         st_d.estat        = st_q.stat;
            st_d.stat[IE_BIT]              = 1'b0;
            st_d.stat[CRS_LSB +: SET_W]    = tgt_set;
        end else if (eret) begin
            st_d.stat = (cur_set == '0) ? st_q.estat : st_q.sst[cur_set];
            if (!SHADOW_EN) st_d.stat[CRS_LSB +: SET_W] = '0;
        end else begin
            if (stat_we) begin
                st_d.stat                   = stat_wdata;
                st_d.stat[CRS_LSB +: SET_W] = cur_set;
            end
            if (estat_we) st_d.estat = estat_wdata;
            if (sstat_we && SHADOW_EN && cur_set != '0) st_d.sst[cur_set] = sstat_wdata;
        end
        if (!SHADOW_EN) st_d.sst = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o    = st_q.stat;
    assign estat_o   = st_q.estat;
    assign cur_set_o = cur_set;

    if (SHADOW_EN) begin : g_sst_out
        assign sstat_o = (cur_set == '0) ? '0 : st_q.sst[cur_set];
    end else begin : g_sst_zero
        assign sstat_o = '0;
    end

    p_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (SHADOW_EN && irq_take && irq_set != '0 && !hnd_mode) |=> sstat_o == $past(stat_o));

    p_no_save_hnd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (SHADOW_EN && irq_take && irq_set != '0 && hnd_mode) |=> sstat_o == $past(st_q.sst[irq_set]));

    p_set_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !irq_take && !eret) |=> $stable(cur_set_o));

    p_eret_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (SHADOW_EN && eret && !irq_take && cur_set_o == '0) |=> stat_o == $past(estat_o));

    p_eret_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !irq_take && cur_set_o != '0) |=> stat_o == $past(sstat_o));

    p_entry_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (SHADOW_EN && irq_take) |=> (cur_set_o == $past(irq_set)) && !stat_o[IE_BIT]);

    p_flat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !SHADOW_EN |-> cur_set_o == '0);
endmodule

// File: rtl/regset_ctrl.sv
module regset_ctrl #(
    parameter int NUM_SETS  = 4,
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 16,
    parameter bit SHADOW_EN = 1'b1,
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_take,
    input  logic [SET_W-1:0]  irq_set,
    input  logic              hnd_mode,
    input  logic              eret,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              estat_we,
    input  logic [STAT_W-1:0] estat_wdata,
    input  logic              sstat_we,
    input  logic [STAT_W-1:0] sstat_wdata,
    output logic [STAT_W-1:0] stat_o,
    output logic [STAT_W-1:0] estat_o,
    output logic [STAT_W-1:0] sstat_o,
    output logic [SET_W-1:0]  cur_set_o,
    input  logic              rf_we,
    input  logic [ADDR_W-1:0] rf_waddr,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic [ADDR_W-1:0] rf_raddr,
    output logic [DATA_W-1:0] rf_rdata,
    input  logic [SET_W-1:0]  xr_set,
    input  logic [ADDR_W-1:0] xr_addr,
    output logic [DATA_W-1:0] xr_data
);
    logic [SET_W-1:0] cur_set;

    regset_stat #(
        .NUM_SETS (NUM_SETS),
        .STAT_W   (STAT_W),
        .SHADOW_EN(SHADOW_EN)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_take   (irq_take),
        .irq_set    (irq_set),
        .hnd_mode   (hnd_mode),
        .eret       (eret),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .estat_we   (estat_we),
        .estat_wdata(estat_wdata),
        .sstat_we   (sstat_we),
        .sstat_wdata(sstat_wdata),
        .stat_o     (stat_o),
        .estat_o    (estat_o),
        .sstat_o    (sstat_o),
        .cur_set_o  (cur_set)
    );

    assign cur_set_o = cur_set;

    regset_rf #(
        .NUM_SETS(NUM_SETS),
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W)
    ) u_rf (
        .clk  (clk),
        .we   (rf_we),
        .wset (cur_set),
        .waddr(rf_waddr),
        .wdata(rf_wdata),
        .rset (cur_set),
        .raddr(rf_raddr),
        .rdata(rf_rdata),
        .xset (xr_set),
        .xaddr(xr_addr),
        .xdata(xr_data)
    );

    // Cross-set port aimed at the current set must agree with the normal port
    p_xread_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_set == cur_set && xr_addr == rf_raddr) |-> xr_data == rf_rdata);
endmodule

// File: tb/regset_ctrl_bench.sv
module regset_ctrl_bench;
    localparam int SET_W  = 2;
    localparam int ADDR_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              irq_take = 0, hnd_mode = 0, eret = 0;
    logic [SET_W-1:0]  irq_set = '0;
    logic              stat_we = 0, estat_we = 0, sstat_we = 0;
    logic [15:0]       stat_wdata = '0, estat_wdata = '0, sstat_wdata = '0;
    logic [15:0]       stat_o, estat_o, sstat_o, f_stat, f_estat, f_sstat;
    logic [SET_W-1:0]  cur_set_o, f_set, xr_set = '0;
    logic              rf_we = 0;
    logic [ADDR_W-1:0] rf_waddr = '0, rf_raddr = '0, xr_addr = '0;
    logic [31:0]       rf_wdata = '0, rf_rdata, xr_data, f_rd, f_xd;

    regset_ctrl #(.STAT_W(16)) u_regset_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_set(irq_set),
        .hnd_mode(hnd_mode), .eret(eret), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .estat_we(estat_we), .estat_wdata(estat_wdata), .sstat_we(sstat_we),
        .sstat_wdata(sstat_wdata), .stat_o(stat_o), .estat_o(estat_o),
        .sstat_o(sstat_o), .cur_set_o(cur_set_o), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .xr_set(xr_set), .xr_addr(xr_addr), .xr_data(xr_data));

    regset_ctrl #(.STAT_W(16), .SHADOW_EN(1'b0)) u_regset_ctrl_flat (
        .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_set(irq_set),
        .hnd_mode(hnd_mode), .eret(eret), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .estat_we(estat_we), .estat_wdata(estat_wdata), .sstat_we(sstat_we),
        .sstat_wdata(sstat_wdata), .stat_o(f_stat), .estat_o(f_estat),
        .sstat_o(f_sstat), .cur_set_o(f_set), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(f_rd),
        .xr_set(xr_set), .xr_addr(xr_addr), .xr_data(f_xd));

    // Signal selectors for the scoreboard
    localparam int S_STAT = 0, S_SET = 1, S_ESTAT = 2, S_SST = 3,
                   S_RD = 4, S_XD = 5, S_FSET = 6, S_FSST = 7;

    typedef struct { int sel; logic [31:0] exp; string req; } item_t;
    item_t exp_q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic push(int sel, logic [31:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    function automatic logic [31:0] pick(int sel);
        case (sel)
            S_STAT:  return 32'(stat_o);
            S_SET:   return 32'(cur_set_o);
            S_ESTAT: return 32'(estat_o);
            S_SST:   return 32'(sstat_o);
            S_RD:    return rf_rdata;
            S_XD:    return xr_data;
            S_FSET:  return 32'(f_set);
            default: return 32'(f_sstat);
        endcase
    endfunction

    // Monitor: compares pending expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = pick(it.sel);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); rst_n = 1; cyc();
        // R1 reset state
        push(S_STAT, 0, "R1"); push(S_SET, 0, "R1");
        push(S_ESTAT, 0, "R1"); push(S_SST, 0, "R1");
        cyc();
        // R4 status write with set bits 3: set field ignored
        stat_we = 1; stat_wdata = 16'h0355; cyc(); stat_we = 0;
        push(S_STAT, 32'h0055, "R4"); push(S_SET, 0, "R4");
        // put 0xA0 at reg 5 of set 0
        rf_we = 1; rf_waddr = 5; rf_wdata = 32'hA0; cyc(); rf_we = 0;
        // R2/R8 entry into set 2, handler mode low
        irq_take = 1; irq_set = 2; cyc(); irq_take = 0;
        push(S_SST, 32'h0055, "R2"); push(S_STAT, 32'h0254, "R8");
        push(S_SET, 2, "R8"); push(S_FSET, 0, "R11"); push(S_FSST, 0, "R11");
        // R9 write in the very next cycle lands in set 2
        rf_we = 1; rf_waddr = 5; rf_wdata = 32'hA2; cyc(); rf_we = 0;
        rf_raddr = 5; xr_set = 0; xr_addr = 5;
        push(S_RD, 32'hA2, "R9"); push(S_XD, 32'hA0, "R10");
        cyc();
        xr_set = 2; push(S_XD, 32'hA2, "R10");
        // R6 return from shadow set 2 through its saved-status word
        sstat_we = 1; sstat_wdata = 16'h0311; cyc(); sstat_we = 0;
        push(S_SST, 32'h0311, "R6");
        eret = 1; cyc(); eret = 0;
        push(S_STAT, 32'h0311, "R6"); push(S_SET, 3, "R6");
        push(S_RD, 32'hA2 ^ 32'hA2 ^ 32'hx, "R9");
        exp_q.pop_back();
        // R3 entry into set 1 with handler mode high: no save
        irq_take = 1; irq_set = 1; hnd_mode = 1; cyc(); irq_take = 0; hnd_mode = 0;
        push(S_SST, 0, "R3"); push(S_SET, 1, "R3"); push(S_STAT, 32'h0110, "R8");
        // R6 return from set 1 (saved word zero)
        estat_we = 1; estat_wdata = 16'h0280; cyc(); estat_we = 0;
        eret = 1; cyc(); eret = 0;
        push(S_STAT, 0, "R6"); push(S_SET, 0, "R6");
        // R5 return from normal set through exception status
        eret = 1; cyc(); eret = 0;
        push(S_STAT, 32'h0280, "R5"); push(S_SET, 2, "R5");
        push(S_ESTAT, 32'h0280, "R5");
        // R3 entry requesting set 0: old status to exception status
        irq_take = 1; irq_set = 0; cyc(); irq_take = 0;
        push(S_ESTAT, 32'h0280, "R3"); push(S_SET, 0, "R3");
        push(S_STAT, 32'h0080, "R3");
        // R7 entry and return together: entry wins
        estat_we = 1; estat_wdata = 16'h0190; cyc(); estat_we = 0;
        irq_take = 1; eret = 1; irq_set = 3; cyc(); irq_take = 0; eret = 0;
        push(S_SET, 3, "R7"); push(S_SST, 32'h0080, "R7");
        push(S_STAT, 32'h0380, "R7");
        push(S_FSET, 0, "R11"); push(S_FSST, 0, "R11");
        cyc(); cyc();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule